// File: doc/BRIEF.md
# UART Transmit Control-Character Injector

This block sits in a UART transmit path between the source of buffered transmit characters and the serializer. Between them it keeps a small transmit FIFO. Software can post one urgent control character, such as a flow-control XON or XOFF, into a single-entry holding register. That register carries a pending flag. Whenever the transmitter is enabled, the block checks the holding register on every cycle. A pending control character enters the FIFO ahead of any further buffer characters. It never jumps over characters already queued in the FIFO.

The FIFO normally holds four characters, so a control character may wait up to four character times behind queued data. A depth-select input cuts the usable FIFO capacity to a single character, which bounds that wait. The depth select is captured only while the transmitter is disabled, so it should be set before transmission is enabled. A freeze control stops buffer characters from entering the FIFO, but it does not stop the control character.

Top module: `txinj_top`

## Requirements
- R1: After synchronous reset the FIFO is empty (`ser_valid` low), no control character is pending (`oos_pending` low), and the depth selection is the full depth.
- R2: The FIFO presents its oldest character on `ser_data` with `ser_valid` high whenever it is non-empty. A character leaves on each cycle where `ser_valid` and `ser_ready` are both high, and characters leave in the order they entered.
- R3: With full depth selected, the FIFO holds at most DEPTH (default 4) characters. No character is pushed in a cycle that starts with the FIFO at capacity, and `buf_ready` is low in such a cycle.
- R4: While a control character is pending, `buf_ready` is low. If there is space in the FIFO and the transmitter is enabled, the control character is pushed in that cycle.
- R5: Characters already in the FIFO when the control character is posted leave before it does.
- R6: While `freeze` is high, `buf_ready` is low and no buffer character is taken. A pending control character is still pushed when there is space.
- R7: While `tx_en` is low, nothing is pushed, `buf_ready` is low, and a pending control character stays pending.
- R8: A write on `oos_wr` sets `oos_pending` from the next cycle on. The flag clears on the cycle after the control character is pushed into the FIFO.
- R9: A write while `oos_pending` is set replaces the held character. Only the last written value is transmitted.
- R10: The depth selection is captured from `depth_one` only on cycles where `tx_en` is low. When 1 was captured, the usable capacity is one character, and changes to `depth_one` while enabled have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| freeze | input | 1 | Hold back buffer characters |
| depth_one | input | 1 | 1 selects single-character FIFO capacity (captured while disabled) |
| oos_wr | input | 1 | Write strobe for the control-character register |
| oos_data | input | CHAR_W | Control character to post |
| oos_pending | output | 1 | Control character waiting for FIFO entry |
| buf_valid | input | 1 | Buffer character available |
| buf_data | input | CHAR_W | Buffer character |
| buf_ready | output | 1 | Buffer character accepted this cycle when valid |
| ser_valid | output | 1 | FIFO non-empty, head character valid |
| ser_data | output | CHAR_W | Head character of the FIFO |
| ser_ready | input | 1 | Serializer takes the head character |

## Verification
On every cycle, the assertions check the following cycle-local rules: the fill level never passes the depth, `buf_ready` is blocked by a pending control character, by freeze, by a disabled transmitter and by a full single-entry FIFO, the head stays stable while it is stalled, and the pending flag sets after a write, holds while disabled, and clears after a push into an empty FIFO. Other behaviour spans many cycles, and only the bench's scenarios can show it. This covers the order in which the control character emerges relative to queued data, the replacement of a pending character, the push of a control character under freeze, and the capture of the depth selection only while disabled.

// File: rtl/txinj_pkg.sv
package txinj_pkg;
    parameter int CHAR_W     = 8;
    parameter int FIFO_DEPTH = 4;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        logic  vld;
        char_t data;
    } push_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CTRL = 2'd1,
        SRC_BUF  = 2'd2
    } src_e;

    function automatic int unsigned cap_of(input logic single, input int unsigned full_depth);
        return single ? 1 : full_depth;
    endfunction
endpackage

// File: rtl/txinj_oos_reg.sv
module txinj_oos_reg
    import txinj_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  char_t wdata,
    input  logic  take,
    output logic  pending,
    output char_t held
);
    // A write wins over a same-cycle take: the new value stays pending (R9).
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            held    <= '0;
        end else if (wr) begin
            pending <= 1'b1;
            held    <= wdata;
        end else if (take) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/txinj_arb.sv
module txinj_arb
    import txinj_pkg::*;
(
    input  logic  tx_en,
    input  logic  freeze,
    input  logic  space,
    input  logic  ctrl_pending,
    input  char_t ctrl_data,
    input  logic  buf_valid,
    input  char_t buf_data,
    output logic  buf_ready,
    output logic  take_ctrl,
    output push_t push
);
    src_e src;

    always_comb begin
        src = SRC_NONE;
        if (tx_en && space) begin
            if (ctrl_pending)
                src = SRC_CTRL;
            else if (buf_valid && !freeze)
                src = SRC_BUF;
        end
    end

    always_comb begin
        push = '0;
        unique case (src)
            SRC_CTRL: push = '{vld: 1'b1, data: ctrl_data};
            SRC_BUF:  push = '{vld: 1'b1, data: buf_data};
            default:  push = '0;
        endcase
    end

    assign take_ctrl = (src == SRC_CTRL);
    assign buf_ready = tx_en && space && !freeze && !ctrl_pending;
endmodule

// File: rtl/txinj_fifo.sv
module txinj_fifo
    import txinj_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_one,
    input  push_t         push,
    input  logic          pop_ready,
    output logic          out_valid,
    output char_t         out_data,
    output logic [CW-1:0] fill,
    output logic          space
);
    char_t         mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign out_valid = (fill != '0);
    assign out_data  = mem[rd_ptr];
    assign pop       = out_valid && pop_ready;
    assign space     = fill < CW'(cap_of(cap_one, DEPTH));

    always_ff @(posedge clk) begin
        if (push.vld)
            mem[wr_ptr] <= push.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push.vld) wr_ptr <= bump(wr_ptr);
            if (pop)      rd_ptr <= bump(rd_ptr);
            case ({push.vld, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/txinj_top.sv
module txinj_top
    import txinj_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              freeze,
    input  logic              depth_one,
    input  logic              oos_wr,
    input  logic [CHAR_W-1:0] oos_data,
    output logic              oos_pending,
    input  logic              buf_valid,
    input  logic [CHAR_W-1:0] buf_data,
    output logic              buf_ready,
    output logic              ser_valid,
    output logic [CHAR_W-1:0] ser_data,
    input  logic              ser_ready
);
    logic          cap_one_q;
    logic          take_ctrl;
    logic          space;
    char_t         ctrl_data;
    push_t         push;
    logic [CW-1:0] fill;

    // Depth selection is captured only while the transmitter is off (R10).
    always_ff @(posedge clk) begin
        if (rst)
            cap_one_q <= 1'b0;
        else if (!tx_en)
            cap_one_q <= depth_one;
    end

    txinj_oos_reg u_oos (
        .clk     (clk),
        .rst     (rst),
        .wr      (oos_wr),
        .wdata   (oos_data),
        .take    (take_ctrl),
        .pending (oos_pending),
        .held    (ctrl_data)
    );

    txinj_arb u_arb (
        .tx_en        (tx_en),
        .freeze       (freeze),
        .space        (space),
        .ctrl_pending (oos_pending),
        .ctrl_data    (ctrl_data),
        .buf_valid    (buf_valid),
        .buf_data     (buf_data),
        .buf_ready    (buf_ready),
        .take_ctrl    (take_ctrl),
        .push         (push)
    );

    txinj_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .cap_one   (cap_one_q),
        .push      (push),
        .pop_ready (ser_ready),
        .out_valid (ser_valid),
        .out_data  (ser_data),
        .fill      (fill),
        .space     (space)
    );
endmodule

// File: rtl/txinj_chk.sv
module txinj_chk
    import txinj_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_en,
    input logic              freeze,
    input logic              oos_wr,
    input logic              oos_pending,
    input logic              buf_ready,
    input logic              ser_valid,
    input logic              ser_ready,
    input logic [CHAR_W-1:0] ser_data,
    input logic [CW-1:0]     fill,
    input logic              cap_one
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    p_ctrl_blocks_buf_r4: assert property (@(posedge clk) disable iff (rst)
        oos_pending |-> !buf_ready);

    p_freeze_blocks_buf_r6: assert property (@(posedge clk) disable iff (rst)
        freeze |-> !buf_ready);

    p_disabled_blocks_buf_r7: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !buf_ready);

    p_disabled_holds_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && oos_pending) |=> oos_pending);

    p_flag_sets_r8: assert property (@(posedge clk) disable iff (rst)
        oos_wr |=> oos_pending);

    p_flag_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (oos_pending && tx_en && !oos_wr && fill == '0) |=> !oos_pending);

    p_head_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_data)));

    p_single_cap_r10: assert property (@(posedge clk) disable iff (rst)
        (cap_one && fill != '0) |-> !buf_ready);
endmodule

bind txinj_top txinj_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .freeze      (freeze),
    .oos_wr      (oos_wr),
    .oos_pending (oos_pending),
    .buf_ready   (buf_ready),
    .ser_valid   (ser_valid),
    .ser_ready   (ser_ready),
    .ser_data    (ser_data),
    .fill        (fill),
    .cap_one     (cap_one_q)
);

// File: tb/txinj_top_tb.sv
module txinj_top_tb;
    logic       clk = 1'b0;
    logic       rst, tx_en, freeze, depth_one, oos_wr, buf_valid, ser_ready;
    logic [7:0] oos_data, buf_data, ser_data;
    logic       oos_pending, buf_ready, ser_valid;
    int         total = 0;
    int         bad   = 0;
    bit         done  = 1'b0;

    always #5 clk = ~clk;

    txinj_top u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .freeze(freeze), .depth_one(depth_one),
        .oos_wr(oos_wr), .oos_data(oos_data), .oos_pending(oos_pending),
        .buf_valid(buf_valid), .buf_data(buf_data), .buf_ready(buf_ready),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_ready(ser_ready)
    );

    typedef struct packed {
        logic       en, frz, wr;
        logic [7:0] od;
        logic       bv;
        logic [7:0] bd;
        logic       rdy;
        logic       e_br, e_sv;
        logic [7:0] e_sd;
        logic       e_p;
    } row_t;

    // Full depth (4). Inputs are applied, outputs checked, then the clock edge.
    localparam int NROWS = 21;
    localparam row_t ROWS [NROWS] = '{
        '{1,0,0,8'h00,1,8'hA0,0, 1,0,8'h00,0}, // R2 first push
        '{1,0,0,8'h00,1,8'hA1,0, 1,1,8'hA0,0}, // R2
        '{1,0,1,8'h13,1,8'hA2,0, 1,1,8'hA0,0}, // R8 post control char
        '{1,0,0,8'h00,1,8'hA3,0, 0,1,8'hA0,1}, // R4 control beats buffer
        '{1,0,0,8'h00,1,8'hA3,0, 0,1,8'hA0,0}, // R3 full
        '{1,0,0,8'h00,1,8'hA3,1, 0,1,8'hA0,0}, // R3 full at start, pop
        '{1,0,0,8'h00,1,8'hA3,1, 1,1,8'hA1,0}, // R2
        '{1,0,0,8'h00,0,8'h00,1, 1,1,8'hA2,0}, // R5 queued first
        '{1,0,0,8'h00,0,8'h00,1, 1,1,8'h13,0}, // R5 control after queued
        '{1,1,1,8'h11,1,8'hA4,0, 0,1,8'hA3,0}, // R6 freeze
        '{1,1,0,8'h00,1,8'hA4,0, 0,1,8'hA3,1}, // R6 control pushed under freeze
        '{1,1,0,8'h00,1,8'hA4,0, 0,1,8'hA3,0}, // R6
        '{0,0,1,8'h22,1,8'hA4,0, 0,1,8'hA3,0}, // R7 disabled
        '{0,0,1,8'h33,1,8'hA4,0, 0,1,8'hA3,1}, // R9 replace
        '{0,0,0,8'h00,1,8'hA4,0, 0,1,8'hA3,1}, // R7 held
        '{1,0,0,8'h00,1,8'hA4,0, 0,1,8'hA3,1}, // R4
        '{1,0,0,8'h00,1,8'hA4,1, 1,1,8'hA3,0}, // R2
        '{1,0,0,8'h00,0,8'h00,1, 1,1,8'h11,0}, // R6 frozen control out
        '{1,0,0,8'h00,0,8'h00,1, 1,1,8'h33,0}, // R9 only last value
        '{1,0,0,8'h00,0,8'h00,1, 1,1,8'hA4,0}, // R2
        '{1,0,0,8'h00,0,8'h00,0, 1,0,8'h00,0}  // R2 empty
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic en, frz, wr, input logic [7:0] od,
                         input logic bv, input logic [7:0] bd, input logic rdy);
        tx_en = en; freeze = frz; oos_wr = wr; oos_data = od;
        buf_valid = bv; buf_data = bd; ser_ready = rdy;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst = 1'b1; depth_one = 1'b0;
        drive(0, 0, 0, 8'h00, 0, 8'h00, 0);
        tick(); tick();
        rst = 1'b0;
        #3;
        chk("R1 ser_valid", {7'd0, ser_valid}, 8'h00);
        chk("R1 oos_pending", {7'd0, oos_pending}, 8'h00);
        chk("R1 buf_ready", {7'd0, buf_ready}, 8'h00);
        tick();

        for (int i = 0; i < NROWS; i++) begin
            drive(ROWS[i].en, ROWS[i].frz, ROWS[i].wr, ROWS[i].od,
                  ROWS[i].bv, ROWS[i].bd, ROWS[i].rdy);
            #3;
            chk($sformatf("row %0d buf_ready", i), {7'd0, buf_ready}, {7'd0, ROWS[i].e_br});
            chk($sformatf("row %0d ser_valid", i), {7'd0, ser_valid}, {7'd0, ROWS[i].e_sv});
            if (ROWS[i].e_sv)
                chk($sformatf("row %0d ser_data", i), ser_data, ROWS[i].e_sd);
            chk($sformatf("row %0d oos_pending", i), {7'd0, oos_pending}, {7'd0, ROWS[i].e_p});
            tick();
        end

        // R10: single-character capacity captured while disabled.
        rst = 1'b1; depth_one = 1'b1;
        drive(0, 0, 0, 8'h00, 0, 8'h00, 0);
        tick();
        rst = 1'b0;
        tick();                                   // depth_one captured, tx_en low
        depth_one = 1'b0;                         // ignored once enabled
        drive(1, 0, 0, 8'h00, 1, 8'hB0, 0);
        #3; chk("R10 first push accepted", {7'd0, buf_ready}, 8'h01);
        tick();
        drive(1, 0, 1, 8'hCC, 1, 8'hB1, 0);
        #3; chk("R10 capacity one blocks", {7'd0, buf_ready}, 8'h00);
        tick();
        drive(1, 0, 0, 8'h00, 1, 8'hB1, 1);
        #3; chk("R10 head", ser_data, 8'hB0);
        chk("R4 waits on full", {7'd0, oos_pending}, 8'h01);
        tick();
        drive(1, 0, 0, 8'h00, 1, 8'hB1, 0);
        #3; chk("R10 empty after pop", {7'd0, ser_valid}, 8'h00);
        chk("R4 buffer blocked", {7'd0, buf_ready}, 8'h00);
        tick();
        drive(1, 0, 0, 8'h00, 1, 8'hB1, 0);
        #3; chk("R8 flag cleared", {7'd0, oos_pending}, 8'h00);
        chk("R5 control next", ser_data, 8'hCC);
        chk("R10 full again", {7'd0, buf_ready}, 8'h00);
        tick();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule